// File: doc/BRIEF.md
# Logical Shift-Right Accumulate Unit

This unit is the datapath step behind multi-word logical right shifts. It takes a 16-bit operand, places it in the upper half of a 32-bit accumulator body, and moves it right by a count of 0 to 15. Zeros enter from the left. Bits that leave the upper half land in the lower half instead of being lost. The shifted value is added to the body of a 36-bit accumulator. The sum's top bit is copied into the 4-bit extension field, and the new value is registered along with a negative flag and a zero flag.

Software builds a wide right shift by running the unit once per source word. Each run feeds the unit's previous result back in as the accumulator input, so the pieces of adjacent words merge through the add. A valid strobe marks each operation. The result appears one clock later, and the registered accumulator holds its value in cycles without a strobe.

Top module: `lsra_top`

## Requirements
- R1: The addend is the operand in bits 31:16 of a 32-bit word with zeros in bits 15:0, shifted right logically by the count. Zeros enter at bit 31, and bits shifted past bit 16 continue into the lower half.
- R2: The count is bits 3:0 of `srcAmt`, so it ranges from 0 to 15. Bits 15:4 of `srcAmt` have no effect on the result.
- R3: The result body (bits 31:0) is `accIn[31:0]` plus the addend, modulo 2^32. A carry out of bit 15 reaches the upper half. `accIn[35:32]` has no effect on the result.
- R4: Result bits 35:32 all equal result bit 31. No saturation is applied.
- R5: `flagNeg` is result bit 35.
- R6: `flagZero` is 1 exactly when all 36 result bits are zero.
- R7: When `inValid` is high at a rising clock edge, the result and flags appear at the outputs after that edge. `outValid` is high for exactly the following cycle.
- R8: When `inValid` is low at an edge, `accOut`, `flagNeg` and `flagZero` keep their values and `outValid` is low.
- R9: When `rst` is high at an edge, the edge clears `accOut`, `flagNeg`, `flagZero` and `outValid` to 0 (synchronous reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation strobe |
| srcVal | input | 16 | Operand to shift |
| srcAmt | input | 16 | Shift count holder; only bits 3:0 are used |
| accIn | input | 36 | Current accumulator (extension:high:low) |
| accOut | output | 36 | Registered updated accumulator |
| flagNeg | output | 1 | Registered bit 35 of the result |
| flagZero | output | 1 | Registered all-zero indication of the result |
| outValid | output | 1 | High the cycle after a strobed operation |

## Verification
The bench builds the unit at its default widths: a 16-bit operand, a 4-bit count and a 4-bit extension. At these widths every count from 0 to 15 is reachable. So are both ends of the shift range, where the operand stays in the upper half at count 0 and only one bit remains there at count 15. A behavioural model using plain wide vectors predicts each clock's outputs. The directed vectors cover an operand with its top bit set, a carry from the lower half into the upper half, and a sum that wraps to zero. Further vectors set the high count bits or the incoming extension bits to values that must have no effect.

// File: rtl/lsra_pkg.sv
package lsra_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic capture;  // load a new result and flags
    logic clear;    // force registers to zero
  } lsraCtl_t;
endpackage

// File: rtl/lsra_shift.sv
// Logarithmic right shifter: one stage per count bit.
module lsra_shift #(
  parameter int WIDTH = 32,
  parameter int CNTW  = 4
) (
  input  logic [WIDTH-1:0] dIn,
  input  logic [CNTW-1:0]  amt,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] stage [CNTW+1];

  assign stage[0] = dIn;

  for (genvar k = 0; k < CNTW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    always_comb begin
      if (amt[k]) stage[k+1] = {{STEP{1'b0}}, stage[k][WIDTH-1:STEP]};
      else        stage[k+1] = stage[k];
    end
  end

  assign dOut = stage[CNTW];
endmodule

// File: rtl/lsra_ctrl.sv
module lsra_ctrl
  import lsra_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  output lsraCtl_t ctl,
  output logic     outValid
);
  always_comb begin
    ctl.clear   = rst;
    ctl.capture = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/lsra_dp.sv
module lsra_dp
  import lsra_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int CNTW = 4,
  parameter int EXTW = 4
) (
  input  logic                      clk,
  input  lsraCtl_t                  ctl,
  input  logic [OPW-1:0]            srcVal,
  input  logic [OPW-1:0]            srcAmt,
  input  logic [EXTW+2*OPW-1:0]     accIn,
  output logic [EXTW+2*OPW-1:0]     accOut,
  output logic                      flagNeg,
  output logic                      flagZero
);
  localparam int BODYW = 2 * OPW;
  localparam int ACCW  = EXTW + BODYW;

  logic [CNTW-1:0]  shiftAmt;
  logic [BODYW-1:0] aligned;
  logic [BODYW-1:0] addend;
  logic [BODYW-1:0] sumBody;
  logic [ACCW-1:0]  nextAcc;

  assign shiftAmt = srcAmt[CNTW-1:0];
  assign aligned  = {srcVal, {OPW{1'b0}}};

  lsra_shift #(.WIDTH(BODYW), .CNTW(CNTW)) u_shift (
    .dIn  (aligned),
    .amt  (shiftAmt),
    .dOut (addend)
  );

  assign sumBody = accIn[BODYW-1:0] + addend;
  assign nextAcc = {{EXTW{sumBody[BODYW-1]}}, sumBody};

  always_ff @(posedge clk) begin
    if (ctl.clear) begin
      accOut   <= '0;
      flagNeg  <= 1'b0;
      flagZero <= 1'b0;
    end else if (ctl.capture) begin
      accOut   <= nextAcc;
      flagNeg  <= nextAcc[ACCW-1];
      flagZero <= (nextAcc == '0);
    end
  end
endmodule

// File: rtl/lsra_top.sv
module lsra_top
  import lsra_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int CNTW = 4,
  parameter int EXTW = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inValid,
  input  logic [OPW-1:0]        srcVal,
  input  logic [OPW-1:0]        srcAmt,
  input  logic [EXTW+2*OPW-1:0] accIn,
  output logic [EXTW+2*OPW-1:0] accOut,
  output logic                  flagNeg,
  output logic                  flagZero,
  output logic                  outValid
);
  lsraCtl_t ctl;

  lsra_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .ctl      (ctl),
    .outValid (outValid)
  );

  lsra_dp #(.OPW(OPW), .CNTW(CNTW), .EXTW(EXTW)) u_dp (
    .clk      (clk),
    .ctl      (ctl),
    .srcVal   (srcVal),
    .srcAmt   (srcAmt),
    .accIn    (accIn),
    .accOut   (accOut),
    .flagNeg  (flagNeg),
    .flagZero (flagZero)
  );
endmodule

// File: rtl/lsra_chk.sv
module lsra_chk #(
  parameter int OPW  = 16,
  parameter int CNTW = 4,
  parameter int EXTW = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  inValid,
  input logic [EXTW+2*OPW-1:0] accOut,
  input logic                  flagNeg,
  input logic                  flagZero,
  input logic                  outValid
);
  localparam int BODYW = 2 * OPW;
  localparam int ACCW  = EXTW + BODYW;

  logic loaded;  // a result has been captured since reset
  always_ff @(posedge clk) begin
    if (rst)           loaded <= 1'b0;
    else if (outValid) loaded <= 1'b1;
  end

  // R4
  ext_sign_chk: assert property (@(posedge clk) disable iff (rst)
    accOut[ACCW-1:BODYW] == {EXTW{accOut[BODYW-1]}});

  // R5
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    flagNeg == accOut[ACCW-1]);

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    loaded |-> (flagZero == (accOut == '0)));

  // R7
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(accOut) && $stable(flagNeg) && $stable(flagZero) && !outValid));

  // R9
  reset_clr_chk: assert property (@(posedge clk)
    rst |=> (accOut == '0 && !flagNeg && !flagZero && !outValid));
endmodule

bind lsra_top lsra_chk #(.OPW(OPW), .CNTW(CNTW), .EXTW(EXTW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .accOut   (accOut),
  .flagNeg  (flagNeg),
  .flagZero (flagZero),
  .outValid (outValid)
);

// File: tb/lsra_top_tb.sv
module lsra_top_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [15:0] srcVal;
  logic [15:0] srcAmt;
  logic [35:0] accIn;
  logic [35:0] accOut;
  logic        flagNeg, flagZero, outValid;

  int vectors = 0;
  int misses  = 0;

  // reference state
  logic [35:0] mAcc;
  logic        mNeg, mZero, mValid;

  always #2 clk = ~clk;  // 250 MHz

  lsra_top u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .srcVal(srcVal), .srcAmt(srcAmt),
    .accIn(accIn), .accOut(accOut), .flagNeg(flagNeg), .flagZero(flagZero),
    .outValid(outValid)
  );

  // behavioural model of one clock edge
  task automatic modelEdge();
    logic [63:0] wide;
    logic [31:0] body;
    int          cnt;
    if (rst) begin
      mAcc = '0; mNeg = 0; mZero = 0; mValid = 0;
    end else if (inValid) begin
      cnt  = int'(srcAmt % 16);
      wide = (64'(srcVal) * 64'd65536) / (64'd1 << cnt);
      body = 32'(64'(accIn % 36'h1_0000_0000) + wide);
      mAcc = body[31] ? {4'hF, body} : {4'h0, body};
      mNeg = mAcc[35];
      mZero = (mAcc == 36'd0);
      mValid = 1;
    end else begin
      mValid = 0;
    end
  endtask

  task automatic compare(input string tag);
    vectors++;
    if (accOut !== mAcc || flagNeg !== mNeg || flagZero !== mZero || outValid !== mValid) begin
      misses++;
      $display("FAIL %s: acc=%h n=%b z=%b v=%b expected acc=%h n=%b z=%b v=%b",
               tag, accOut, flagNeg, flagZero, outValid, mAcc, mNeg, mZero, mValid);
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [15:0] s,
                      input logic [15:0] a, input logic [35:0] acc, input string tag);
    @(negedge clk);
    rst = r; inValid = v; srcVal = s; srcAmt = a; accIn = acc;
    @(posedge clk);
    modelEdge();
    #1 compare(tag);
  endtask

  // also check a fixed expected value written from the requirements
  task automatic expectAcc(input logic [35:0] want, input string tag);
    vectors++;
    if (accOut !== want) begin
      misses++;
      $display("FAIL %s: acc=%h expected %h", tag, accOut, want);
    end
  endtask

  initial begin
    rst = 1; inValid = 0; srcVal = 0; srcAmt = 0; accIn = 0;
    mAcc = 'x; mNeg = 'x; mZero = 'x; mValid = 'x;
    step(1, 0, 16'h0, 16'h0, 36'h0, "R9 reset");
    step(1, 1, 16'hFFFF, 16'h0, 36'h1234, "R9 reset overrides strobe");

    step(0, 1, 16'hC003, 16'h0004, 36'h0_0000_0099, "R1 basic");
    expectAcc(36'h0_0C00_3099, "R1 basic value");
    step(0, 1, 16'h8001, 16'h0000, 36'h0, "R4 R5 count0 msb");
    expectAcc(36'hF_8001_0000, "R4 count0 value");
    step(0, 1, 16'h8000, 16'h000F, 36'h0, "R1 count15");
    expectAcc(36'h0_0001_0000, "R1 count15 value");
    step(0, 1, 16'hFFFF, 16'h000F, 36'h0, "R1 count15 all ones");
    expectAcc(36'h0_0001_FFFE, "R1 count15 ones value");
    step(0, 1, 16'hC003, 16'hFFF4, 36'h0_0000_0099, "R2 upper count bits");
    expectAcc(36'h0_0C00_3099, "R2 value");
    step(0, 1, 16'hC003, 16'h0004, 36'hA_0000_0099, "R3 ext input ignored");
    expectAcc(36'h0_0C00_3099, "R3 ext value");
    step(0, 1, 16'h0001, 16'h0004, 36'h0_0000_F000, "R3 low to high carry");
    expectAcc(36'h0_0001_0000, "R3 carry value");
    step(0, 1, 16'h0001, 16'h0000, 36'h0_FFFF_0000, "R6 wrap to zero");
    expectAcc(36'h0, "R6 zero value");
    step(0, 1, 16'hF000, 16'h0000, 36'h0_7000_0000, "R4 R5 positive overflow");
    step(0, 0, 16'h1234, 16'h0001, 36'h0_5555_5555, "R8 hold");
    step(0, 0, 16'hFFFF, 16'h0003, 36'h0, "R8 hold again");
    step(0, 1, 16'h4321, 16'h0007, 36'h3_0000_0001, "R7 strobe after idle");
    step(1, 0, 16'h0, 16'h0, 36'h0, "R9 reset mid run");
    for (int i = 0; i < 60; i++) begin
      step(0, ($urandom % 4) != 0, 16'($urandom), 16'($urandom), 36'({$urandom, $urandom}),
           "R1 R3 random");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule